// File: doc/BRIEF.md
# Interrupt Context-Switch Sequencer

This block takes over at an instruction boundary when the interrupt controller has a request pending. It reads the level of the winning request and clears it in the pending register. It then works through the in-memory tables for that level. A pointer read from the level's linkage slot gives the area where the running context (status word, mask, instruction counter) is stored. A pointer read from the level's service slot gives the area that holds the incoming context. Two status-write I/O commands frame the switch: one carries an all-zero word and one carries the new status word. The last step is a single restart strobe that carries the new instruction counter.

The address-state field of the incoming status word is checked. When no memory-management unit is present, a non-zero field is forced to zero. The block then records an address-state error in its fault register and raises a level-1 request towards the interrupt controller. The same fault register also captures eight active-low user fault lines on each falling edge of a bus synchronisation signal. All fault bits stay set until reset.

Top module: `irq_ctx_seq`

States of the sequencer:
- IDLE
- CAPT (capture the level)
- RD_LP (read linkage pointer)
- WR_SW, WR_MK, WR_IC (save the old context)
- RD_SP (read service pointer)
- IO_ZERO (zero status write)
- RD_MK (new mask)
- RD_SW (new status word)
- IO_NEW (corrected status write)
- RD_IC (new counter and restart)

Transitions:
- IDLE moves to CAPT when `instr_done` and `irq_req` are both high.
- CAPT moves to RD_LP unconditionally.
- IO_ZERO moves to RD_MK unconditionally.
- IO_NEW moves to RD_IC unconditionally.
- Every memory state moves to the next state in the list above on `mem_ack`.
- RD_IC returns to IDLE.

## Requirements
- R1: After reset the block is idle (`busy` low), with no memory request, no I/O strobe, no restart and a fault register of all zeros.
- R2: A service sequence starts only in a cycle where `instr_done` and `irq_req` are both high; a request without an instruction boundary leaves the block idle with no memory activity.
- R3: In the cycle after acceptance, `irq_clr` pulses for exactly one cycle with `irq_clr_lvl` equal to `irq_vec`, and `dl_vec` holds that level until the next service.
- R4: For level n the linkage pointer is read from word address 0x20+2n and the service pointer from 0x21+2n; these are the first and second reads of a sequence.
- R5: Using linkage pointer L, the current status word, mask and instruction counter are written to L, L+1 and L+2, in that order.
- R6: Every memory access holds `mem_req`, `mem_addr` and `mem_we` stable until the cycle in which `mem_ack` is high.
- R7: Exactly two status-write I/O strobes are issued per sequence, never together with a memory request. The first carries 0x0000 and comes after the two pointer reads and before the new mask read. The second carries the new status word.
- R8: Using service pointer S, the word at S is presented on `mk_new` with a `mk_ld` pulse, and `int_dis` pulses in the same cycle.
- R9: The word at S+1 is the new status word, with the address-state field in bits 3:0. If that field is non-zero and `mmu_present` is low, it is forced to zero, fault bit 11 is set and `as_irq` pulses once. Otherwise the word passes unchanged, with no fault and no pulse. The result appears on `sw_new` with `sw_ld`.
- R10: The word at S+2 is presented on `ic_new` with a one-cycle `restart` pulse, and the block is idle in the following cycle.
- R11: On each falling edge of `sync_n`, every low line of `usr_flt_n[7:0]` sets the fault bit of the same index. A line that goes low while `sync_n` is already low is not captured, and fault bits never clear.
- R12: A request held during a sequence is not accepted again until the block has returned to idle, so each sequence produces exactly one `irq_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Current instruction has completed |
| irq_req | input | 1 | Interrupt controller has an unmasked request |
| irq_vec | input | 4 | Encoded highest pending level |
| mmu_present | input | 1 | Memory-management unit fitted |
| cur_sw | input | 16 | Running status word |
| cur_mk | input | 16 | Running mask |
| cur_ic | input | 16 | Running instruction counter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ack |
| mem_ack | input | 1 | Access complete |
| io_sw_stb | output | 1 | Status-write I/O command strobe |
| io_sw_data | output | 16 | Status-write I/O data |
| irq_clr | output | 1 | Clear strobe for serviced level |
| irq_clr_lvl | output | 4 | Level to clear |
| dl_vec | output | 4 | Captured level |
| mk_ld | output | 1 | Load new mask |
| mk_new | output | 16 | New mask value |
| int_dis | output | 1 | Disable interrupts |
| sw_ld | output | 1 | Load new status word |
| sw_new | output | 16 | New (corrected) status word |
| restart | output | 1 | Restart execution at new counter |
| ic_new | output | 16 | New instruction counter |
| as_irq | output | 1 | Address-state fault raises level 1 |
| sync_n | input | 1 | Bus sync, falling edge samples faults |
| usr_flt_n | input | 8 | Active-low user fault lines |
| fault_q | output | 16 | Fault register |
| busy | output | 1 | Sequence in progress |

## Verification
The strobes `irq_clr`, `mk_ld`, `int_dis`, `sw_ld`, `restart`, `io_sw_stb` and `as_irq` are decoded from the state, so they are observed in the cycle their state is active. Fault bits appear one edge after the falling `sync_n` edge or the `as_irq` pulse. `busy` falls one edge after `restart`. The bench memory model answers one nanosecond after a clock edge, with a chosen latency. A monitor samples at the falling clock edge and records every access, strobe and value in the order it occurs. Each scenario task then compares that log with values worked out from its own table contents, so no check depends on process order at the active edge.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CAPT,
        S_RD_LP,
        S_WR_SW,
        S_WR_MK,
        S_WR_IC,
        S_RD_SP,
        S_IO_ZERO,
        S_RD_MK,
        S_RD_SW,
        S_IO_NEW,
        S_RD_IC
    } ctx_state_e;
endpackage

// File: rtl/irq_ptr_calc.sv
module irq_ptr_calc #(
    parameter int          AW       = 16,
    parameter int          LW       = 4,
    parameter logic [15:0] PTR_BASE = 16'h0020
) (
    input  logic [LW-1:0] lvl,
    output logic [AW-1:0] lp_addr,
    output logic [AW-1:0] sp_addr
);
    localparam int SHIFT_W = LW + 1;

    logic [SHIFT_W-1:0] twice;

    // each level owns a pair of words: linkage slot then service slot
    assign twice   = {lvl, 1'b0};
    assign lp_addr = AW'(PTR_BASE) + AW'(twice);
    assign sp_addr = AW'(PTR_BASE) + AW'(twice) + AW'(1);
endmodule

// File: rtl/irq_fault_reg.sv
module irq_fault_reg #(
    parameter int FW     = 16,
    parameter int USR_N  = 8,
    parameter int AS_BIT = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n,
    input  logic [USR_N-1:0] usr_flt_n,
    input  logic             as_set,
    output logic [FW-1:0]    fault_q
);
    logic          sync_d;
    logic          sync_fall;
    logic [FW-1:0] set_vec;

    assign sync_fall = sync_d & ~sync_n;

    for (genvar i = 0; i < FW; i++) begin : g_bit
        if (i < USR_N) begin : g_usr
            assign set_vec[i] = sync_fall & ~usr_flt_n[i];
        end else if (i == AS_BIT) begin : g_as
            assign set_vec[i] = as_set;
        end else begin : g_none
            assign set_vec[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_d  <= 1'b1;
            fault_q <= '0;
        end else begin
            sync_d  <= sync_n;
            fault_q <= fault_q | set_vec;
        end
    end
endmodule

// File: rtl/irq_ctx_fsm.sv
module irq_ctx_fsm
    import irq_ctx_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int LW   = 4,
    parameter int AS_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_done,
    input  logic          irq_req,
    input  logic [LW-1:0] irq_vec,
    input  logic          mmu_present,
    input  logic [DW-1:0] cur_sw,
    input  logic [DW-1:0] cur_mk,
    input  logic [DW-1:0] cur_ic,
    input  logic [AW-1:0] lp_addr,
    input  logic [AW-1:0] sp_addr,
    output logic [LW-1:0] lvl_q,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          io_sw_stb,
    output logic [DW-1:0] io_sw_data,
    output logic          irq_clr,
    output logic [LW-1:0] irq_clr_lvl,
    output logic          mk_ld,
    output logic [DW-1:0] mk_new,
    output logic          int_dis,
    output logic          sw_ld,
    output logic [DW-1:0] sw_new,
    output logic          restart,
    output logic [DW-1:0] ic_new,
    output logic          as_set,
    output logic          busy
);
    ctx_state_e    state, state_nx;
    logic [AW-1:0] lptr_q;
    logic [AW-1:0] sptr_q;
    logic [DW-1:0] sw_q;
    logic          as_err_q;
    logic          as_bad;

    assign as_bad = !mmu_present && (mem_rdata[AS_W-1:0] != '0);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (instr_done && irq_req) state_nx = S_CAPT;
            S_CAPT:    state_nx = S_RD_LP;
            S_RD_LP:   if (mem_ack) state_nx = S_WR_SW;
            S_WR_SW:   if (mem_ack) state_nx = S_WR_MK;
            S_WR_MK:   if (mem_ack) state_nx = S_WR_IC;
            S_WR_IC:   if (mem_ack) state_nx = S_RD_SP;
            S_RD_SP:   if (mem_ack) state_nx = S_IO_ZERO;
            S_IO_ZERO: state_nx = S_RD_MK;
            S_RD_MK:   if (mem_ack) state_nx = S_RD_SW;
            S_RD_SW:   if (mem_ack) state_nx = S_IO_NEW;
            S_IO_NEW:  state_nx = S_RD_IC;
            S_RD_IC:   if (mem_ack) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // state register and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            lvl_q    <= '0;
            lptr_q   <= '0;
            sptr_q   <= '0;
            sw_q     <= '0;
            as_err_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_CAPT) lvl_q <= irq_vec;
            if (state == S_RD_LP && mem_ack) lptr_q <= mem_rdata[AW-1:0];
            if (state == S_RD_SP && mem_ack) sptr_q <= mem_rdata[AW-1:0];
            if (state == S_RD_SW && mem_ack) begin
                as_err_q <= as_bad;
                if (as_bad) sw_q <= {mem_rdata[DW-1:AS_W], {AS_W{1'b0}}};
                else        sw_q <= mem_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        io_sw_stb   = 1'b0;
        io_sw_data  = '0;
        irq_clr     = 1'b0;
        irq_clr_lvl = '0;
        mk_ld       = 1'b0;
        int_dis     = 1'b0;
        sw_ld       = 1'b0;
        restart     = 1'b0;
        as_set      = 1'b0;
        mk_new      = mem_rdata;
        ic_new      = mem_rdata;
        sw_new      = sw_q;
        busy        = (state != S_IDLE);
        unique case (state)
            S_IDLE: ;
            S_CAPT: begin
                irq_clr     = 1'b1;
                irq_clr_lvl = irq_vec;
            end
            S_RD_LP: begin
                mem_req  = 1'b1;
                mem_addr = lp_addr;
            end
            S_WR_SW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lptr_q;
                mem_wdata = cur_sw;
            end
            S_WR_MK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lptr_q + AW'(1);
                mem_wdata = cur_mk;
            end
            S_WR_IC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lptr_q + AW'(2);
                mem_wdata = cur_ic;
            end
            S_RD_SP: begin
                mem_req  = 1'b1;
                mem_addr = sp_addr;
            end
            S_IO_ZERO: begin
                io_sw_stb  = 1'b1;
                io_sw_data = '0;
            end
            S_RD_MK: begin
                mem_req  = 1'b1;
                mem_addr = sptr_q;
                mk_ld    = mem_ack;
                int_dis  = mem_ack;
            end
            S_RD_SW: begin
                mem_req  = 1'b1;
                mem_addr = sptr_q + AW'(1);
            end
            S_IO_NEW: begin
                io_sw_stb  = 1'b1;
                io_sw_data = sw_q;
                sw_ld      = 1'b1;
                as_set     = as_err_q;
            end
            S_RD_IC: begin
                mem_req  = 1'b1;
                mem_addr = sptr_q + AW'(2);
                restart  = mem_ack;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq #(
    parameter int          AW       = 16,
    parameter int          DW       = 16,
    parameter int          LW       = 4,
    parameter int          AS_W     = 4,
    parameter int          FW       = 16,
    parameter int          USR_N    = 8,
    parameter int          AS_BIT   = 11,
    parameter logic [15:0] PTR_BASE = 16'h0020
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_done,
    input  logic             irq_req,
    input  logic [LW-1:0]    irq_vec,
    input  logic             mmu_present,
    input  logic [DW-1:0]    cur_sw,
    input  logic [DW-1:0]    cur_mk,
    input  logic [DW-1:0]    cur_ic,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ack,
    output logic             io_sw_stb,
    output logic [DW-1:0]    io_sw_data,
    output logic             irq_clr,
    output logic [LW-1:0]    irq_clr_lvl,
    output logic [LW-1:0]    dl_vec,
    output logic             mk_ld,
    output logic [DW-1:0]    mk_new,
    output logic             int_dis,
    output logic             sw_ld,
    output logic [DW-1:0]    sw_new,
    output logic             restart,
    output logic [DW-1:0]    ic_new,
    output logic             as_irq,
    input  logic             sync_n,
    input  logic [USR_N-1:0] usr_flt_n,
    output logic [FW-1:0]    fault_q,
    output logic             busy
);
    logic [AW-1:0] lp_addr;
    logic [AW-1:0] sp_addr;
    logic          as_set;

    irq_ptr_calc #(.AW(AW), .LW(LW), .PTR_BASE(PTR_BASE)) u_ptr (
        .lvl     (dl_vec),
        .lp_addr (lp_addr),
        .sp_addr (sp_addr)
    );

    irq_ctx_fsm #(.AW(AW), .DW(DW), .LW(LW), .AS_W(AS_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_done  (instr_done),
        .irq_req     (irq_req),
        .irq_vec     (irq_vec),
        .mmu_present (mmu_present),
        .cur_sw      (cur_sw),
        .cur_mk      (cur_mk),
        .cur_ic      (cur_ic),
        .lp_addr     (lp_addr),
        .sp_addr     (sp_addr),
        .lvl_q       (dl_vec),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack),
        .io_sw_stb   (io_sw_stb),
        .io_sw_data  (io_sw_data),
        .irq_clr     (irq_clr),
        .irq_clr_lvl (irq_clr_lvl),
        .mk_ld       (mk_ld),
        .mk_new      (mk_new),
        .int_dis     (int_dis),
        .sw_ld       (sw_ld),
        .sw_new      (sw_new),
        .restart     (restart),
        .ic_new      (ic_new),
        .as_set      (as_set),
        .busy        (busy)
    );

    irq_fault_reg #(.FW(FW), .USR_N(USR_N), .AS_BIT(AS_BIT)) u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_n    (sync_n),
        .usr_flt_n (usr_flt_n),
        .as_set    (as_set),
        .fault_q   (fault_q)
    );

    assign as_irq = as_set;
endmodule

// File: rtl/irq_ctx_chk.sv
module irq_ctx_chk #(
    parameter int AW     = 16,
    parameter int FW     = 16,
    parameter int AS_BIT = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_done,
    input logic          irq_req,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          io_sw_stb,
    input logic          irq_clr,
    input logic          as_irq,
    input logic [FW-1:0] fault_q,
    input logic          restart,
    input logic          busy
);
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(instr_done && irq_req)) |=> !busy);

    p_clr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> (busy && !irq_clr));

    p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_io_no_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_sw_stb |-> !mem_req);

    p_as_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        as_irq |=> fault_q[AS_BIT]);

    p_idle_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !busy);

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
endmodule

bind irq_ctx_seq irq_ctx_chk #(.AW(AW), .FW(FW), .AS_BIT(AS_BIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_done (instr_done),
    .irq_req    (irq_req),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .io_sw_stb  (io_sw_stb),
    .irq_clr    (irq_clr),
    .as_irq     (as_irq),
    .fault_q    (fault_q),
    .restart    (restart),
    .busy       (busy)
);

// File: tb/test_irq_ctx_seq.sv
`timescale 1ns/1ps
module test_irq_ctx_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_done = 1'b0;
    logic        irq_req = 1'b0;
    logic [3:0]  irq_vec = '0;
    logic        mmu_present = 1'b0;
    logic [15:0] cur_sw = '0, cur_mk = '0, cur_ic = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        io_sw_stb;
    logic [15:0] io_sw_data;
    logic        irq_clr;
    logic [3:0]  irq_clr_lvl, dl_vec;
    logic        mk_ld, int_dis, sw_ld, restart, as_irq, busy;
    logic [15:0] mk_new, sw_new, ic_new, fault_q;
    logic        sync_n = 1'b1;
    logic [7:0]  usr_flt_n = 8'hFF;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    irq_ctx_seq i_irq_ctx_seq (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .irq_req(irq_req),
        .irq_vec(irq_vec), .mmu_present(mmu_present), .cur_sw(cur_sw),
        .cur_mk(cur_mk), .cur_ic(cur_ic), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .io_sw_stb(io_sw_stb), .io_sw_data(io_sw_data),
        .irq_clr(irq_clr), .irq_clr_lvl(irq_clr_lvl), .dl_vec(dl_vec),
        .mk_ld(mk_ld), .mk_new(mk_new), .int_dis(int_dis), .sw_ld(sw_ld),
        .sw_new(sw_new), .restart(restart), .ic_new(ic_new), .as_irq(as_irq),
        .sync_n(sync_n), .usr_flt_n(usr_flt_n), .fault_q(fault_q), .busy(busy)
    );

    // memory model: answers just after the active edge
    logic [15:0] mem [0:255];
    int lat = 0;
    int wcnt = 0;
    always @(posedge clk) begin
        cyc++;
        #1;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                wcnt = 0;
                mem_ack = 1'b1;
                mem_rdata = mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
            end else begin
                wcnt++;
            end
        end
    end

    // monitor log, sampled at the falling edge
    logic [15:0] rd_log [0:7];
    logic [15:0] wr_log [0:7];
    logic [15:0] io_log [0:3];
    int rd_n, wr_n, io_n, io0_rd, clr_n, as_n, rst_n_seen;
    logic [3:0]  clr_lvl;
    logic [15:0] mk_seen, sw_seen, ic_seen;
    logic        dis_with_mk;
    logic        monitor_on = 1'b0;

    task automatic clear_log();
        rd_n = 0; wr_n = 0; io_n = 0; io0_rd = -1; clr_n = 0; as_n = 0;
        rst_n_seen = 0; clr_lvl = '0; mk_seen = '0; sw_seen = '0;
        ic_seen = '0; dis_with_mk = 1'b0;
    endtask

    always @(negedge clk) begin
        if (monitor_on) begin
            if (mem_req && mem_ack) begin
                if (mem_we) begin if (wr_n < 8) wr_log[wr_n] = mem_addr; wr_n++; end
                else        begin if (rd_n < 8) rd_log[rd_n] = mem_addr; rd_n++; end
            end
            if (io_sw_stb) begin
                if (io_n < 4) io_log[io_n] = io_sw_data;
                if (io_n == 0) io0_rd = rd_n;
                io_n++;
            end
            if (irq_clr) begin clr_n++; clr_lvl = irq_clr_lvl; end
            if (mk_ld) begin mk_seen = mk_new; dis_with_mk = int_dis; end
            if (sw_ld) sw_seen = sw_new;
            if (as_irq) as_n++;
            if (restart) begin rst_n_seen++; ic_seen = ic_new; end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [15:0] exp_flt = '0;

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 io", io_sw_stb, 0);
        chk("R1 restart", restart, 0);
        chk("R1 fault", fault_q, 0);
    endtask

    task automatic t_no_boundary();
        irq_vec = 4'd3; irq_req = 1'b1; instr_done = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk("R2 idle", {busy, mem_req, irq_clr}, 0);
        end
        irq_req = 1'b0;
    endtask

    task automatic t_service(input int lvl, input int latency, input logic mmu,
                             input logic [15:0] lptr, input logic [15:0] sptr,
                             input logic [15:0] nsw);
        logic [15:0] exp_sw;
        logic        exp_as;
        int          guard;
        lat = latency;
        mmu_present = mmu;
        cur_sw = 16'h1100 + 16'(lvl); cur_mk = 16'h2200 + 16'(lvl); cur_ic = 16'h3300 + 16'(lvl);
        mem[8'h20 + 8'(2*lvl)] = lptr;
        mem[8'h21 + 8'(2*lvl)] = sptr;
        mem[sptr[7:0]]     = 16'h5A00 + 16'(lvl);
        mem[sptr[7:0] + 1] = nsw;
        mem[sptr[7:0] + 2] = 16'h7C00 + 16'(lvl);
        exp_as = !mmu && (nsw[3:0] != 0);
        exp_sw = exp_as ? {nsw[15:4], 4'h0} : nsw;
        clear_log();
        monitor_on = 1'b1;
        @(negedge clk);
        irq_vec = 4'(lvl); irq_req = 1'b1; instr_done = 1'b1;
        guard = 0;
        while (rst_n_seen == 0 && guard < 400) begin @(negedge clk); guard++; end
        irq_req = 1'b0; instr_done = 1'b0;
        chk("R10 restart seen", rst_n_seen, 1);
        @(negedge clk);
        chk("R10 idle after restart", busy, 0);
        monitor_on = 1'b0;
        chk("R3/R12 one clear", clr_n, 1);
        chk("R3 clear level", clr_lvl, lvl);
        chk("R3 dl_vec", dl_vec, lvl);
        chk("R4 linkage ptr addr", rd_log[0], 16'h20 + 16'(2*lvl));
        chk("R4 service ptr addr", rd_log[1], 16'h21 + 16'(2*lvl));
        chk("R5 write count", wr_n, 3);
        chk("R5 write order", {wr_log[0], wr_log[1], wr_log[2]}, {lptr, lptr + 16'd1, lptr + 16'd2});
        chk("R5 saved sw", mem[lptr[7:0]], cur_sw);
        chk("R5 saved mk", mem[lptr[7:0] + 1], cur_mk);
        chk("R5 saved ic", mem[lptr[7:0] + 2], cur_ic);
        chk("R7 io count", io_n, 2);
        chk("R7 zero first", io_log[0], 0);
        chk("R7 zero position", io0_rd, 2);
        chk("R7 new sw io", io_log[1], exp_sw);
        chk("R8 mask addr", rd_log[2], sptr);
        chk("R8 mask value", mk_seen, 16'h5A00 + 16'(lvl));
        chk("R8 int_dis with mk", dis_with_mk, 1);
        chk("R9 sw value", sw_seen, exp_sw);
        chk("R9 as pulse", as_n, exp_as ? 1 : 0);
        if (exp_as) exp_flt[11] = 1'b1;
        chk("R9 fault reg", fault_q, exp_flt);
        chk("R10 ic addr", rd_log[4], sptr + 16'd2);
        chk("R10 ic value", ic_seen, 16'h7C00 + 16'(lvl));
    endtask

    task automatic t_user_faults();
        usr_flt_n = 8'hA5;
        repeat (3) @(negedge clk);
        chk("R11 no edge no latch", fault_q, exp_flt);
        sync_n = 1'b0;
        @(negedge clk); @(negedge clk);
        exp_flt[7:0] = exp_flt[7:0] | 8'h5A;
        chk("R11 edge latch", fault_q, exp_flt);
        usr_flt_n = 8'hFE;
        repeat (3) @(negedge clk);
        chk("R11 low while sync low", fault_q, exp_flt);
        usr_flt_n = 8'hFF; sync_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 sticky", fault_q, exp_flt);
        usr_flt_n = 8'h7F;
        @(negedge clk);
        sync_n = 1'b0;
        @(negedge clk); @(negedge clk);
        exp_flt[7] = 1'b1;
        chk("R11 second edge", fault_q, exp_flt);
        usr_flt_n = 8'hFF; sync_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        clear_log();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_no_boundary();
        t_user_faults();
        t_service(5, 0, 1'b0, 16'h0080, 16'h00A0, 16'hC3E0);
        t_service(0, 3, 1'b1, 16'h0090, 16'h00B0, 16'h4217);
        t_service(15, 1, 1'b0, 16'h00C0, 16'h00D0, 16'h8A49);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc >= 20000);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule